// File: doc/BRIEF.md
# Integer Register File with Zero Entry and Link Port

This block holds the architectural integer state of a load/store RISC datapath: thirty-two 32-bit general registers, read through two independent combinational ports and written through one synchronous port, plus a pair of 32-bit product/quotient registers (upper and lower half) loaded together from a 64-bit input. Entry 0 is a constant zero source: writes aimed at it are discarded.

A separate link port lets the branch unit store a return address (the caller supplies PC+4) into entry 31 in the same cycle as an ordinary write to another entry. If both ports target entry 31 in one cycle, the link value is the one kept. Every write replaces all 32 bits of the entry. A synchronous reset clears all entries and both halves of the product pair.

Top module: `gpr_bank`

## Requirements
- R1: After a synchronous reset, every read port returns 0 for every index, and the upper and lower product registers both read 0.
- R2: With `wr_en` high at a rising edge and `wr_idx` nonzero, the entry `wr_idx` takes the full 32-bit `wr_data`, and both read ports then return it for that index.
- R3: Reading index 0 on either port returns 0 at all times, including after a write to index 0 with nonzero data.
- R4: Read ports are combinational: a change of `rd_idx_a` or `rd_idx_b` shows the addressed entry in the same cycle, with no clock edge between.
- R5: With `lnk_en` high at a rising edge, entry 31 takes `lnk_addr`.
- R6: When `wr_en` with `wr_idx` = 31 and `lnk_en` are both high at one edge, entry 31 takes `lnk_addr` and `wr_data` is dropped.
- R7: When `wr_en` targets an entry other than 31 and `lnk_en` is high at one edge, both writes take effect.
- R8: With `hl_en` high at a rising edge, `hi_q` takes bits 63:32 of `hl_data` and `lo_q` takes bits 31:0; with `hl_en` low both hold.
- R9: With no enable high, no entry changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_idx_a | input | 5 | Index of read port A |
| rd_val_a | output | 32 | Data of read port A |
| rd_idx_b | input | 5 | Index of read port B |
| rd_val_b | output | 32 | Data of read port B |
| wr_en | input | 1 | Write enable of general write port |
| wr_idx | input | 5 | Target index of general write port |
| wr_data | input | 32 | Write data |
| lnk_en | input | 1 | Link write enable (targets entry 31) |
| lnk_addr | input | 32 | Return address to store |
| hl_en | input | 1 | Load enable for product pair |
| hl_data | input | 64 | Upper half to hi_q, lower half to lo_q |
| hi_q | output | 32 | Upper product register |
| lo_q | output | 32 | Lower product register |

## Verification
A corrupted entry stays hidden until some read index selects it, so the bench keeps a model of all 32 entries and sweeps both read ports across every index after each burst of writes; a wrong value shows within one sweep, in the same cycle the index is applied. A leak into entry 0 or a lost link priority shows on the first read of index 0 or 31 after the offending edge. The product pair is visible on its own outputs one edge after the load.

// File: rtl/gpr_bank_pkg.sv
package gpr_bank_pkg;
    parameter int unsigned XLEN    = 32;
    parameter int unsigned NREG    = 32;
    parameter int unsigned IDXW    = $clog2(NREG);
    parameter int unsigned LINKIDX = NREG - 1;

    typedef logic [XLEN-1:0] word_t;
    typedef logic [IDXW-1:0] idx_t;

    typedef struct packed {
        logic  en;
        idx_t  idx;
        word_t data;
    } wreq_t;
endpackage

// File: rtl/gpr_wsel.sv
module gpr_wsel
    import gpr_bank_pkg::*;
(
    input  logic  wr_en,
    input  idx_t  wr_idx,
    input  word_t wr_data,
    input  logic  lnk_en,
    input  word_t lnk_addr,
    output logic [NREG-1:0] sel,
    output word_t [NREG-1:0] val
);
    always_comb begin
        for (int i = 0; i < NREG; i++) begin
            sel[i] = 1'b0;
            val[i] = wr_data;
        end
        if (wr_en && wr_idx != '0) begin
            sel[wr_idx] = 1'b1;
        end
        if (lnk_en) begin
            sel[LINKIDX] = 1'b1;
            val[LINKIDX] = lnk_addr;
        end
    end
endmodule

// File: rtl/gpr_rdport.sv
module gpr_rdport
    import gpr_bank_pkg::*;
(
    input  word_t [NREG-1:0] regs,
    input  idx_t  idx,
    output word_t val
);
    assign val = (idx == '0) ? '0 : regs[idx];
endmodule

// File: rtl/gpr_bank.sv
module gpr_bank
    import gpr_bank_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [4:0]  rd_idx_a,
    output logic [31:0] rd_val_a,
    input  logic [4:0]  rd_idx_b,
    output logic [31:0] rd_val_b,
    input  logic        wr_en,
    input  logic [4:0]  wr_idx,
    input  logic [31:0] wr_data,
    input  logic        lnk_en,
    input  logic [31:0] lnk_addr,
    input  logic        hl_en,
    input  logic [63:0] hl_data,
    output logic [31:0] hi_q,
    output logic [31:0] lo_q
);
    typedef struct packed {
        word_t [NREG-1:0] gpr;
        word_t hi;
        word_t lo;
    } state_t;

    state_t st_d, st_q;
    logic  [NREG-1:0] sel;
    word_t [NREG-1:0] wval;

    gpr_wsel u_wsel (
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .lnk_en(lnk_en), .lnk_addr(lnk_addr),
        .sel(sel), .val(wval)
    );

    always_comb begin
        st_d = st_q;
        for (int i = 1; i < NREG; i++) begin
            if (sel[i]) st_d.gpr[i] = wval[i];
        end
        st_d.gpr[0] = '0;
        if (hl_en) begin
            st_d.hi = hl_data[2*XLEN-1:XLEN];
            st_d.lo = hl_data[XLEN-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    gpr_rdport u_rda (.regs(st_q.gpr), .idx(rd_idx_a), .val(rd_val_a));
    gpr_rdport u_rdb (.regs(st_q.gpr), .idx(rd_idx_b), .val(rd_val_b));

    assign hi_q = st_q.hi;
    assign lo_q = st_q.lo;
endmodule

// File: rtl/gpr_bank_chk.sv
module gpr_bank_chk (
    input logic        clk,
    input logic        rst,
    input logic [4:0]  rd_idx_a,
    input logic [31:0] rd_val_a,
    input logic [4:0]  rd_idx_b,
    input logic [31:0] rd_val_b,
    input logic        wr_en,
    input logic [4:0]  wr_idx,
    input logic        lnk_en,
    input logic [31:0] lnk_addr,
    input logic        hl_en,
    input logic [63:0] hl_data,
    input logic [31:0] hi_q,
    input logic [31:0] lo_q
);
    logic started;
    always_ff @(posedge clk) started <= 1'b1;

    assert_zero_a_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_idx_a == 5'd0) |-> (rd_val_a == 32'd0));
    assert_zero_b_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_idx_b == 5'd0) |-> (rd_val_b == 32'd0));
    assert_link_R5: assert property (@(posedge clk) disable iff (rst || !started)
        (lnk_en && !$past(rst)) ##1 (rd_idx_a == 5'd31 && !rst) |-> (rd_val_a == $past(lnk_addr)));
    assert_hl_load_R8: assert property (@(posedge clk) disable iff (rst)
        hl_en |=> ({hi_q, lo_q} == $past(hl_data)));
    assert_hl_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !hl_en |=> ($stable(hi_q) && $stable(lo_q)));
    assert_same_idx_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_idx_a == rd_idx_b) |-> (rd_val_a == rd_val_b));
endmodule

bind gpr_bank gpr_bank_chk u_chk (
    .clk(clk), .rst(rst),
    .rd_idx_a(rd_idx_a), .rd_val_a(rd_val_a),
    .rd_idx_b(rd_idx_b), .rd_val_b(rd_val_b),
    .wr_en(wr_en), .wr_idx(wr_idx),
    .lnk_en(lnk_en), .lnk_addr(lnk_addr),
    .hl_en(hl_en), .hl_data(hl_data),
    .hi_q(hi_q), .lo_q(lo_q)
);

// File: tb/sim_gpr_bank.sv
`timescale 1ns/1ps
module sim_gpr_bank;
    logic        clk = 1'b0;
    logic        rst;
    logic [4:0]  rd_idx_a, rd_idx_b, wr_idx;
    logic [31:0] rd_val_a, rd_val_b, wr_data, lnk_addr, hi_q, lo_q;
    logic        wr_en, lnk_en, hl_en;
    logic [63:0] hl_data;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] mdl [32];
    logic [31:0] m_hi, m_lo;

    always #2.5 clk = ~clk;

    gpr_bank u0 (.*);

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    function automatic logic [31:0] expect_rd(input logic [4:0] i);
        return (i == 5'd0) ? 32'd0 : mdl[i];
    endfunction

    // Apply one edge; model update per requirements.
    task automatic step(input logic we, input logic [4:0] wi, input logic [31:0] wd,
                        input logic le, input logic [31:0] la,
                        input logic he, input logic [63:0] hd);
        wr_en = we; wr_idx = wi; wr_data = wd;
        lnk_en = le; lnk_addr = la; hl_en = he; hl_data = hd;
        @(posedge clk);
        if (we && wi != 5'd0) mdl[wi] = wd;   // R2, R3
        if (le) mdl[31] = la;                 // R5, R6
        if (he) begin m_hi = hd[63:32]; m_lo = hd[31:0]; end // R8
        #1;
        wr_en = 0; lnk_en = 0; hl_en = 0;
    endtask

    task automatic sweep(input string req);
        for (int i = 0; i < 32; i++) begin
            rd_idx_a = 5'(i); rd_idx_b = 5'(31 - i);
            #0.1; // R4: no edge between index change and sampling
            check(req, rd_val_a, expect_rd(5'(i)));
            check(req, rd_val_b, expect_rd(5'(31 - i)));
        end
    endtask

    initial begin
        #100000;
        n_bad++; n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h1234_5678));
        for (int i = 0; i < 32; i++) mdl[i] = '0;
        m_hi = '0; m_lo = '0;
        rst = 1; wr_en = 0; lnk_en = 0; hl_en = 0;
        wr_idx = 0; wr_data = 0; lnk_addr = 0; hl_data = 0;
        rd_idx_a = 0; rd_idx_b = 0;
        // dirty state first so reset has something to clear
        @(posedge clk); #1;
        rst = 0;
        step(1, 5'd7, 32'hDEAD_BEEF, 1, 32'h100, 1, 64'hFFFF_0000_1234_5678);
        rst = 1;
        @(posedge clk); #1;
        rst = 0;
        for (int i = 0; i < 32; i++) mdl[i] = '0;
        m_hi = '0; m_lo = '0;
        sweep("R1");
        check("R1", hi_q, 32'd0);
        check("R1", lo_q, 32'd0);

        // R3: write to entry 0 ignored
        step(1, 5'd0, 32'hFFFF_FFFF, 0, 0, 0, 0);
        rd_idx_a = 0; rd_idx_b = 0; #0.1;
        check("R3", rd_val_a, 32'd0);
        check("R3", rd_val_b, 32'd0);

        // R2: full-width writes
        step(1, 5'd5, 32'hA5A5_5A5A, 0, 0, 0, 0);
        step(1, 5'd30, 32'h8000_0001, 0, 0, 0, 0);
        sweep("R2");

        // R6: collision on 31, link wins
        step(1, 5'd31, 32'h1111_1111, 1, 32'h0000_4004, 0, 0);
        rd_idx_a = 31; #0.1;
        check("R6", rd_val_a, 32'h0000_4004);

        // R7: both writes land
        step(1, 5'd9, 32'h9999_0009, 1, 32'h0000_8008, 0, 0);
        rd_idx_a = 9; rd_idx_b = 31; #0.1;
        check("R7", rd_val_a, 32'h9999_0009);
        check("R7", rd_val_b, 32'h0000_8008);

        // R5: link alone
        step(0, 5'd31, 32'h0, 1, 32'hCAFE_0000, 0, 0);
        rd_idx_b = 31; #0.1;
        check("R5", rd_val_b, 32'hCAFE_0000);

        // R8: product pair load and hold
        step(0, 0, 0, 0, 0, 1, 64'h0123_4567_89AB_CDEF);
        check("R8", hi_q, 32'h0123_4567);
        check("R8", lo_q, 32'h89AB_CDEF);
        step(0, 0, 0, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF);
        check("R8", hi_q, m_hi);
        check("R8", lo_q, m_lo);

        // R9: data on inputs with all enables low
        step(0, 5'd5, 32'h0BAD_0BAD, 0, 32'h0BAD_0BAD, 0, 0);
        sweep("R9");

        // random traffic
        for (int n = 0; n < 400; n++) begin
            logic [63:0] hd;
            hd = {$urandom(), $urandom()};
            step(1'($urandom() % 4 != 0), 5'($urandom()), $urandom(),
                 1'($urandom() % 5 == 0), $urandom(),
                 1'($urandom() % 3 == 0), hd);
            check("R8", hi_q, m_hi);
            check("R8", lo_q, m_lo);
            if (n % 50 == 49) sweep("R2");
        end
        sweep("R2");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule